// File: doc/BRIEF.md
# Oscillator Amplitude Leveling Controller

This block closes the amplitude-regulation loop of a crystal oscillator in the digital domain. A peak detector and converter deliver a digitized amplitude level, one word per valid strobe. The controller compares each word with a programmed target level and moves a bias-current code, which feeds a current DAC, by one step toward the target. The aim is to hold the swing steady across process and temperature, close to the largest level the supply permits. Only the direction of each step is decided, never its size.

The loop can stay closed at all times, or close only while an external window input is high, for example during a power-up calibration or an idle gap in traffic. Outside a window the bias code is frozen. A ±1 code deadband around the target stops the loop from hunting. After every code change, a programmable number of in-window samples is skipped so the analog path can settle. The code saturates at both ends and flags each bound. A settled output reports that the recent steps have alternated in direction enough times in a row.

Top module: `osc_amp_leveler`

## Requirements
- R1: While rst_n is low at a clock edge, bias_code takes RESET_CODE (32 for a 6-bit code), the holdoff count and the alternation history clear, and settled is low whenever settle_cfg is nonzero.
- R2: A valid in-window sample, taken while no holdoff is pending, whose level is at least 2 below target_code raises bias_code by exactly 1 at the next clock edge.
- R3: A valid in-window sample, taken while no holdoff is pending, whose level is at least 2 above target_code lowers bias_code by exactly 1 at the next clock edge.
- R4: A sample whose level is within 1 of target_code (above, below or equal) leaves bias_code unchanged.
- R5: bias_code changes only at an edge where sample_vld is high, and then by at most one step.
- R6: bias_code never wraps. A raise request at full scale (all ones) and a lower request at 0 leave the code where it is.
- R7: at_floor is high exactly when bias_code is 0, and at_ceiling is high exactly when bias_code is all ones.
- R8: When both run_always and win_en are low, samples change neither bias_code nor the holdoff count.
- R9: After a code change, the next holdoff_cfg valid in-window samples make no decision. The sample after them is evaluated normally.
- R10: Each code step that is opposite in direction to the previous code step adds 1 to an alternation count, which saturates at its maximum. settled is high exactly when that count is at least settle_cfg.
- R11: A code step in the same direction as the previous code step clears the alternation count. The first step after reset leaves the count at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_vld | input | 1 | Amplitude sample strobe |
| sample_code | input | W | Digitized peak amplitude |
| target_code | input | W | Wanted amplitude level |
| run_always | input | 1 | Keep the loop closed at all times |
| win_en | input | 1 | Calibration window open |
| holdoff_cfg | input | HW | Samples skipped after each code change |
| settle_cfg | input | AW | Alternations required for settled |
| bias_code | output | W | Bias current DAC code |
| at_floor | output | 1 | Code is at zero |
| at_ceiling | output | 1 | Code is at full scale |
| settled | output | 1 | Loop dithering about the target |

## Verification
With the target fixed mid-range, every possible amplitude level is applied once. This tells the raise band apart from the deadband and the lower band, and it covers the exact edges at target±1 and target±2. Long runs of a far-off level drive the code into each end, which separates saturation from wrap-around. Bursts with the window shut, with the strobe low and during holdoff tell a frozen loop apart from a live one. Alternating high and low levels, followed by two equal ones, tell the growth of the alternation count apart from its clearing.

// File: rtl/osc_amp_pkg.sv
// Shared types for the oscillator amplitude leveling controller.
// Assumes: nothing beyond a 1800-2017 compiler.
package osc_amp_pkg;
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DN   = 2'd2
    } step_e;
endpackage

// File: rtl/osc_amp_cmp.sv
// Compares an amplitude level against a target using a +/-1 deadband and
// returns the direction the bias code should move.
// Assumes: both words are unsigned and of the same width.
module osc_amp_cmp
    import osc_amp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] level,
    input  logic [W-1:0] target,
    output step_e        req
);
    localparam logic [W:0] GAP = (W+1)'(2);

    logic [W:0] lv_x;
    logic [W:0] tg_x;

    assign lv_x = {1'b0, level};
    assign tg_x = {1'b0, target};

    // Pick a direction only when the level sits outside the deadband.
    always_comb begin
        if (tg_x >= lv_x + GAP)      req = STEP_UP;
        else if (lv_x >= tg_x + GAP) req = STEP_DN;
        else                         req = STEP_NONE;
    end
endmodule

// File: rtl/osc_amp_holdoff.sv
// Counts down the samples skipped after each bias code change.
// Assumes: load only occurs while ready is high, so it never races tick.
module osc_amp_holdoff #(
    parameter int HW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          load,
    input  logic [HW-1:0] cfg,
    output logic          ready
);
    logic [HW-1:0] cnt;

    // Reload on a change, otherwise count in-window samples down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt <= '0;
        else if (load)             cnt <= cfg;
        else if (tick && cnt != 0) cnt <= cnt - 1'b1;
    end

    assign ready = (cnt == '0);
endmodule

// File: rtl/osc_amp_code_reg.sv
// Holds the bias DAC code and applies single saturating steps.
// Assumes: decide is high for at most the one cycle of a valid sample.
module osc_amp_code_reg
    import osc_amp_pkg::*;
#(
    parameter int         W          = 8,
    parameter logic [W-1:0] RESET_CODE = 8'd128
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         decide,
    input  step_e        req,
    output logic [W-1:0] code,
    output logic         step_up,
    output logic         step_dn
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    // A step is taken only if it stays inside the code range.
    always_comb begin
        step_up = decide && (req == STEP_UP) && (code != CODE_MAX);
        step_dn = decide && (req == STEP_DN) && (code != '0);
    end

    // Apply the step chosen this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       code <= RESET_CODE;
        else if (step_up) code <= code + 1'b1;
        else if (step_dn) code <= code - 1'b1;
    end
endmodule

// File: rtl/osc_amp_alt_track.sv
// Counts consecutive direction reversals of the bias code and reports
// settling once the count reaches the programmed threshold.
// Assumes: step_up and step_dn are never high together.
module osc_amp_alt_track #(
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step_up,
    input  logic          step_dn,
    input  logic [AW-1:0] cfg,
    output logic          settled
);
    localparam logic [AW-1:0] ALT_MAX = {AW{1'b1}};

    logic          has_prev;
    logic          prev_up;
    logic [AW-1:0] alt_cnt;
    logic          stepped;

    assign stepped = step_up | step_dn;

    // Update the reversal count and remember the last direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            has_prev <= 1'b0;
            prev_up  <= 1'b0;
            alt_cnt  <= '0;
        end else if (stepped) begin
            has_prev <= 1'b1;
            prev_up  <= step_up;
            if (has_prev && (prev_up != step_up)) begin
                if (alt_cnt != ALT_MAX) alt_cnt <= alt_cnt + 1'b1;
            end else begin
                alt_cnt <= '0;
            end
        end
    end

    assign settled = (alt_cnt >= cfg);
endmodule

// File: rtl/osc_amp_leveler.sv
// Top of the digital amplitude leveling loop: compares each valid amplitude
// sample with the target, steps the bias code inside windows, enforces a
// holdoff after changes and reports bounds and settling.
// Assumes: sample_code is stable while sample_vld is high; all inputs are
// synchronous to clk.
module osc_amp_leveler
    import osc_amp_pkg::*;
#(
    parameter int           W          = 8,
    parameter int           HW         = 4,
    parameter int           AW         = 4,
    parameter logic [W-1:0] RESET_CODE = {1'b1, {(W-1){1'b0}}}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sample_vld,
    input  logic [W-1:0]  sample_code,
    input  logic [W-1:0]  target_code,
    input  logic          run_always,
    input  logic          win_en,
    input  logic [HW-1:0] holdoff_cfg,
    input  logic [AW-1:0] settle_cfg,
    output logic [W-1:0]  bias_code,
    output logic          at_floor,
    output logic          at_ceiling,
    output logic          settled
);
    localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

    step_e req;
    logic  active;
    logic  tick;
    logic  ready;
    logic  decide;
    logic  step_up;
    logic  step_dn;

    // Qualify samples by the loop window and the holdoff state.
    always_comb begin
        active = run_always | win_en;
        tick   = sample_vld & active;
        decide = tick & ready;
    end

    osc_amp_cmp #(.W(W)) u_cmp (
        .level  (sample_code),
        .target (target_code),
        .req    (req)
    );

    osc_amp_holdoff #(.HW(HW)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .load  (step_up | step_dn),
        .cfg   (holdoff_cfg),
        .ready (ready)
    );

    osc_amp_code_reg #(.W(W), .RESET_CODE(RESET_CODE)) u_code (
        .clk     (clk),
        .rst_n   (rst_n),
        .decide  (decide),
        .req     (req),
        .code    (bias_code),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    osc_amp_alt_track #(.AW(AW)) u_alt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_up (step_up),
        .step_dn (step_dn),
        .cfg     (settle_cfg),
        .settled (settled)
    );

    // Bound flags decoded from the held code.
    always_comb begin
        at_floor   = (bias_code == '0);
        at_ceiling = (bias_code == CODE_MAX);
    end
endmodule

// File: rtl/osc_amp_leveler_chk.sv
// Property checker for the amplitude leveling loop, bound to the top.
// Assumes: synchronous active-low reset.
module osc_amp_leveler_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sample_vld,
    input logic [W-1:0] sample_code,
    input logic [W-1:0] target_code,
    input logic         run_always,
    input logic         win_en,
    input logic [W-1:0] bias_code
);
    logic [W:0] lv_x;
    logic [W:0] tg_x;
    logic [W:0] code_x;

    assign lv_x   = {1'b0, sample_code};
    assign tg_x   = {1'b0, target_code};
    assign code_x = {1'b0, bias_code};

    // R8
    freeze_outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_always || win_en) |=> $stable(bias_code));

    // R5
    no_sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_vld |=> $stable(bias_code));

    // R6
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_code) |->
            (code_x == $past(code_x) + 1'b1) || (code_x + 1'b1 == $past(code_x)));

    // R2
    no_fall_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && tg_x >= lv_x + 2) |=> (bias_code >= $past(bias_code)));

    // R3
    no_rise_when_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld && lv_x >= tg_x + 2) |=> (bias_code <= $past(bias_code)));

    // R4
    deadband_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lv_x + 1 >= tg_x && tg_x + 1 >= lv_x) |=> $stable(bias_code));
endmodule

bind osc_amp_leveler osc_amp_leveler_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .sample_code (sample_code),
    .target_code (target_code),
    .run_always  (run_always),
    .win_en      (win_en),
    .bias_code   (bias_code)
);

// File: tb/tb_osc_amp_leveler.sv
`timescale 1ns/1ps
module tb_osc_amp_leveler;
    localparam int W  = 6;
    localparam int HW = 4;
    localparam int AW = 4;
    localparam int CMAX = (1 << W) - 1;
    localparam int AMAX = (1 << AW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample_vld = 1'b0;
    logic [W-1:0]  sample_code = '0;
    logic [W-1:0]  target_code = '0;
    logic          run_always = 1'b1;
    logic          win_en = 1'b0;
    logic [HW-1:0] holdoff_cfg = '0;
    logic [AW-1:0] settle_cfg = 4'd3;
    logic [W-1:0]  bias_code;
    logic          at_floor;
    logic          at_ceiling;
    logic          settled;

    int n_checks = 0;
    int n_fail   = 0;
    int m_code, m_hold, m_alt;
    bit m_has, m_prev_up;

    always #2.5 clk = ~clk;

    osc_amp_leveler #(.W(W), .HW(HW), .AW(AW), .RESET_CODE(6'd32)) dut (
        .clk(clk), .rst_n(rst_n), .sample_vld(sample_vld),
        .sample_code(sample_code), .target_code(target_code),
        .run_always(run_always), .win_en(win_en),
        .holdoff_cfg(holdoff_cfg), .settle_cfg(settle_cfg),
        .bias_code(bias_code), .at_floor(at_floor),
        .at_ceiling(at_ceiling), .settled(settled)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Apply one sample for one cycle, advance the reference model, compare.
    task automatic apply(input int s, input string tag);
        bit up, dn, act;
        @(negedge clk);
        sample_vld  = 1'b1;
        sample_code = W'(s);
        @(negedge clk);
        sample_vld = 1'b0;
        act = run_always || win_en;
        up = 0; dn = 0;
        if (act) begin
            if (m_hold > 0) m_hold--;
            else begin
                if (int'(target_code) >= s + 2 && m_code < CMAX) up = 1;
                if (s >= int'(target_code) + 2 && m_code > 0)   dn = 1;
            end
        end
        if (up || dn) begin
            m_code += up ? 1 : -1;
            m_hold  = holdoff_cfg;
            if (m_has && (m_prev_up != up)) begin
                if (m_alt < AMAX) m_alt++;
            end else m_alt = 0;
            m_has = 1; m_prev_up = up;
        end
        check(tag, bias_code, m_code);
        check("R7 floor", at_floor, m_code == 0);
        check("R7 ceiling", at_ceiling, m_code == CMAX);
        check("R10 settled", settled, m_alt >= settle_cfg);
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        m_code = 32; m_hold = 0; m_alt = 0; m_has = 0; m_prev_up = 0;
        target_code = 6'd30;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 code", bias_code, 32);
        check("R1 settled", settled, 0);
        check("R1 floor", at_floor, 0);
        rst_n = 1'b1;

        // R2/R3/R4: full sweep of levels against target 30
        for (int s = 0; s <= CMAX; s++) begin
            if (s <= 28)      apply(s, "R2 sweep");
            else if (s >= 32) apply(s, "R3 sweep");
            else              apply(s, "R4 sweep");
        end

        // R5: strobe low, far level, no change
        @(negedge clk);
        sample_code = 6'd0;
        repeat (4) @(negedge clk);
        check("R5 no strobe", bias_code, m_code);

        // R8: window shut, then opened
        run_always = 1'b0; win_en = 1'b0;
        for (int i = 0; i < 3; i++) apply(0, "R8 frozen");
        win_en = 1'b1;
        apply(0, "R8 window open");

        // R9: holdoff of 3, including pauses with the window shut
        holdoff_cfg = 4'd3;
        apply(0, "R9 first");
        apply(0, "R9 hold");
        win_en = 1'b0;
        for (int i = 0; i < 4; i++) apply(0, "R8 hold frozen");
        win_en = 1'b1;
        for (int i = 0; i < 4; i++) apply(0, "R9 resume");
        holdoff_cfg = 4'd0;
        run_always = 1'b1;

        // R6: saturate at full scale and at zero
        target_code = 6'd63;
        for (int i = 0; i < 40; i++) apply(0, "R6 ceiling");
        check("R6 at max", bias_code, CMAX);
        check("R7 ceiling flag", at_ceiling, 1);
        target_code = 6'd0;
        for (int i = 0; i < 70; i++) apply(63, "R6 floor");
        check("R6 at zero", bias_code, 0);
        check("R7 floor flag", at_floor, 1);

        // R10/R11: alternate, then repeat a direction
        target_code = 6'd30;
        apply(20, "R10 alt"); apply(40, "R10 alt");
        apply(20, "R10 alt"); apply(40, "R10 alt");
        check("R10 settled high", settled, 1);
        apply(20, "R11 alt"); apply(20, "R11 same dir");
        check("R11 cleared", settled, 0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule